// File: doc/BRIEF.md
# Early-Firing Two-Way Elastic Multiplexer

This block merges two elastic data streams under the control of a third elastic stream that carries a one-bit choice. A result leaves as soon as the choice token and the token of the chosen input are both present. The block does not wait for the other input. Each data input is a dual channel. It carries the usual forward valid and backward stop for positive tokens. It also carries a backward kill, which offers an anti-token to the producer, and a forward kill-hold, which the producer raises to refuse that anti-token.

When the block fires without the other input's token, it records one debt for that input in a small up-down counter. While the debt is nonzero, the next positive token arriving on that input is accepted and thrown away, and the debt drops by one. A producer that has no token ready may instead absorb the anti-token by lowering kill-hold, and then skips its next item. Every firing therefore uses up exactly one item from each input. Output item k is always item k of input A or input B, as named by choice token k.

Results pass through a two-entry output queue, so the output's stop does not reach the inputs combinationally.

Top module: `early_sel_mux`

## Requirements
- R1: With the choice token present and equal to 0 (input A), a valid A token with no pending debt on A, and a free output slot, the block fires in that cycle whether or not B has a token. A is accepted (`a_stop` low) and the A data appears on `out_data` with `out_vld` high in the following cycle. Choice value 1 selects B symmetrically.
- R2: If a firing finds no usable token on the unselected input, that input's debt rises by one, and its kill output is high from the next cycle on.
- R3: A positive token arriving while its input's debt is nonzero is accepted (stop low) and discarded. It never reaches the output, and each such token lowers the debt by one. After as many arrivals as the debt, kill is low.
- R4: A firing in which both inputs hold usable tokens consumes both, in the same cycle, and creates no debt.
- R5: If the unselected input has no usable token and its debt equals KILL_DEPTH, the block does not fire. `sel_stop` stays high and the selected input is not accepted.
- R6: On each data input, kill and stop are never high together. The producer must keep kill-hold low whenever it drives valid.
- R7: Under arbitrary upstream gaps, producer absorption and output stops, the output sequence equals, item by item, the selected input's item at the same index.
- R8: While `out_vld` is high and `out_stop` is high, the output holds its data in the next cycle. With two results queued, no further firing occurs.
- R9: After reset, `out_vld`, `a_kill` and `b_kill` are low.
- R10: When kill is high, valid is low and kill-hold is low, the producer absorbs one anti-token and the debt drops by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_vld | input | 1 | Choice token present |
| sel_pick | input | 1 | Choice value: 0 selects A, 1 selects B |
| sel_stop | output | 1 | Choice token not accepted this cycle |
| a_vld | input | 1 | Positive token present on A |
| a_data | input | DW | A payload |
| a_stop | output | 1 | A token not accepted this cycle |
| a_kill | output | 1 | Anti-token offered to the A producer |
| a_kill_hold | input | 1 | A producer refuses the anti-token |
| b_vld | input | 1 | Positive token present on B |
| b_data | input | DW | B payload |
| b_stop | output | 1 | B token not accepted this cycle |
| b_kill | output | 1 | Anti-token offered to the B producer |
| b_kill_hold | input | 1 | B producer refuses the anti-token |
| out_vld | output | 1 | Result token present |
| out_data | output | DW | Result payload |
| out_stop | input | 1 | Consumer refuses the result |

## Verification
The assertions watch, on every cycle, the exclusion of kill and stop on each input and the producer's matching obligation. They also check that a saturated debt blocks firing, that an early firing raises kill on the skipped input, that a full firing accepts both inputs, and that a stalled output holds its data. Only the bench's scenarios can show that anti-tokens cancel exactly the right late items and that the output order matches the reference selection. This is shown over long runs with random gaps, absorption and output stops, and the bench also confirms that all debt is cleared at the end.

// File: rtl/eemux_pkg.sv
package eemux_pkg;
    typedef enum logic {
        PICK_A = 1'b0,
        PICK_B = 1'b1
    } pick_e;

    localparam int NUM_IN = 2;
endpackage

// File: rtl/eemux_kill_ctr.sv
module eemux_kill_ctr #(
    parameter int KILL_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic kill_hold_i,
    output logic kill_o,
    output logic full_o
);
    localparam int CW = $clog2(KILL_DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;
    logic dec;

    assign kill_o = (st_q.cnt != '0);
    assign full_o = (st_q.cnt == CW'(KILL_DEPTH));

    always_comb begin
        st_d = st_q;
        // one anti-token leaves when the producer does not hold it off
        dec = kill_o & ~kill_hold_i;
        st_d.cnt = st_q.cnt + CW'(inc_i) - CW'(dec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/eemux_fire.sv
module eemux_fire
    import eemux_pkg::*;
(
    input  logic              sel_vld_i,
    input  logic              sel_pick_i,
    input  logic [NUM_IN-1:0] vld_i,
    input  logic [NUM_IN-1:0] kill_i,
    input  logic [NUM_IN-1:0] full_i,
    input  logic              room_i,
    output logic              fire_o,
    output logic [NUM_IN-1:0] stop_o,
    output logic [NUM_IN-1:0] inc_o
);
    logic [NUM_IN-1:0] want;
    logic [NUM_IN-1:0] usable;
    logic [NUM_IN-1:0] ready;

    always_comb begin
        want = (pick_e'(sel_pick_i) == PICK_B) ? 2'b10 : 2'b01;
        for (int i = 0; i < NUM_IN; i++) begin
            // a token counts only when no debt waits to cancel it
            usable[i] = vld_i[i] & ~kill_i[i];
            ready[i]  = want[i] ? usable[i] : (usable[i] | ~full_i[i]);
        end
        fire_o = sel_vld_i & room_i & (&ready);
        for (int i = 0; i < NUM_IN; i++) begin
            inc_o[i]  = fire_o & ~want[i] & ~usable[i];
            stop_o[i] = ~(kill_i[i] | (fire_o & usable[i]));
        end
    end
endmodule

// File: rtl/eemux_obuf.sv
module eemux_obuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    output logic          room_o,
    output logic          out_vld_o,
    output logic [DW-1:0] out_data_o,
    input  logic          out_stop_i
);
    typedef struct packed {
        logic [1:0][DW-1:0] mem;
        logic               wr;
        logic               rd;
        logic [1:0]         cnt;
    } buf_t;

    buf_t st_d, st_q;
    logic pop;

    assign out_vld_o  = (st_q.cnt != 2'd0);
    assign out_data_o = st_q.mem[st_q.rd];
    assign room_o     = (st_q.cnt != 2'd2);

    always_comb begin
        st_d = st_q;
        pop  = out_vld_o & ~out_stop_i;
        if (push_i) begin
            st_d.mem[st_q.wr] = push_data_i;
            st_d.wr = ~st_q.wr;
        end
        if (pop) st_d.rd = ~st_q.rd;
        st_d.cnt = st_q.cnt + 2'(push_i) - 2'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/early_sel_mux.sv
module early_sel_mux
    import eemux_pkg::*;
#(
    parameter int DW         = 8,
    parameter int KILL_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_vld,
    input  logic          sel_pick,
    output logic          sel_stop,
    input  logic          a_vld,
    input  logic [DW-1:0] a_data,
    output logic          a_stop,
    output logic          a_kill,
    input  logic          a_kill_hold,
    input  logic          b_vld,
    input  logic [DW-1:0] b_data,
    output logic          b_stop,
    output logic          b_kill,
    input  logic          b_kill_hold,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    input  logic          out_stop
);
    logic [NUM_IN-1:0] vld_w, kill_w, full_w, inc_w, stop_w, hold_w;
    logic              fire_w, room_w;
    logic [DW-1:0]     pick_data;

    assign vld_w  = {b_vld, a_vld};
    assign hold_w = {b_kill_hold, a_kill_hold};

    for (genvar g = 0; g < NUM_IN; g++) begin : g_debt
        eemux_kill_ctr #(.KILL_DEPTH(KILL_DEPTH)) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_i      (inc_w[g]),
            .kill_hold_i(hold_w[g]),
            .kill_o     (kill_w[g]),
            .full_o     (full_w[g])
        );
    end

    eemux_fire u_fire (
        .sel_vld_i (sel_vld),
        .sel_pick_i(sel_pick),
        .vld_i     (vld_w),
        .kill_i    (kill_w),
        .full_i    (full_w),
        .room_i    (room_w),
        .fire_o    (fire_w),
        .stop_o    (stop_w),
        .inc_o     (inc_w)
    );

    assign pick_data = (pick_e'(sel_pick) == PICK_B) ? b_data : a_data;

    eemux_obuf #(.DW(DW)) u_obuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (fire_w),
        .push_data_i(pick_data),
        .room_o     (room_w),
        .out_vld_o  (out_vld),
        .out_data_o (out_data),
        .out_stop_i (out_stop)
    );

    assign sel_stop = ~fire_w;
    assign a_stop   = stop_w[0];
    assign b_stop   = stop_w[1];
    assign a_kill   = kill_w[0];
    assign b_kill   = kill_w[1];
endmodule

// File: rtl/eemux_chk.sv
module eemux_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel_vld,
    input logic          sel_pick,
    input logic          sel_stop,
    input logic          a_vld,
    input logic          a_stop,
    input logic          a_kill,
    input logic          a_kill_hold,
    input logic          b_vld,
    input logic          b_stop,
    input logic          b_kill,
    input logic          b_kill_hold,
    input logic          out_vld,
    input logic [DW-1:0] out_data,
    input logic          out_stop,
    input logic          fire,
    input logic [1:0]    full
);
    assert_kill_stop_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_kill && a_stop));
    assert_kill_stop_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_kill && b_stop));
    assert_prod_hold_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        a_vld |-> !a_kill_hold);
    assert_prod_hold_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        b_vld |-> !b_kill_hold);
    assert_block_full_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && !sel_pick && !(b_vld && !b_kill) && full[1]) |-> sel_stop);
    assert_block_full_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld && sel_pick && !(a_vld && !a_kill) && full[0]) |-> sel_stop);
    assert_early_kill_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !sel_pick && !(b_vld && !b_kill)) |=> b_kill);
    assert_early_kill_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sel_pick && !(a_vld && !a_kill)) |=> a_kill);
    assert_both_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && a_vld && !a_kill && b_vld && !b_kill) |-> (!a_stop && !b_stop));
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && out_stop) |=> (out_vld && $stable(out_data)));
endmodule

bind early_sel_mux eemux_chk #(.DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_vld    (sel_vld),
    .sel_pick   (sel_pick),
    .sel_stop   (sel_stop),
    .a_vld      (a_vld),
    .a_stop     (a_stop),
    .a_kill     (a_kill),
    .a_kill_hold(a_kill_hold),
    .b_vld      (b_vld),
    .b_stop     (b_stop),
    .b_kill     (b_kill),
    .b_kill_hold(b_kill_hold),
    .out_vld    (out_vld),
    .out_data   (out_data),
    .out_stop   (out_stop),
    .fire       (fire_w),
    .full       (full_w)
);

// File: tb/early_sel_mux_tb_top.sv
`timescale 1ns/1ps
module early_sel_mux_tb_top;
    localparam int DW = 8;
    localparam int KD = 2;
    localparam int N  = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_vld = 1'b0, sel_pick = 1'b0, sel_stop;
    logic          a_vld = 1'b0, a_stop, a_kill, a_kill_hold = 1'b1;
    logic          b_vld = 1'b0, b_stop, b_kill, b_kill_hold = 1'b1;
    logic [DW-1:0] a_data = '0, b_data = '0;
    logic          out_vld, out_stop = 1'b0;
    logic [DW-1:0] out_data;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    early_sel_mux #(.DW(DW), .KILL_DEPTH(KD)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sel_vld(sel_vld), .sel_pick(sel_pick), .sel_stop(sel_stop),
        .a_vld(a_vld), .a_data(a_data), .a_stop(a_stop), .a_kill(a_kill), .a_kill_hold(a_kill_hold),
        .b_vld(b_vld), .b_data(b_data), .b_stop(b_stop), .b_kill(b_kill), .b_kill_hold(b_kill_hold),
        .out_vld(out_vld), .out_data(out_data), .out_stop(out_stop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // passive producers: hold off anti-tokens except while offering a token
    task automatic drive(input logic av, input logic [DW-1:0] ad, input logic bv,
                         input logic [DW-1:0] bd, input logic sv, input logic sp);
        a_vld = av; a_data = ad; a_kill_hold = ~av;
        b_vld = bv; b_data = bd; b_kill_hold = ~bv;
        sel_vld = sv; sel_pick = sp;
    endtask

    function automatic logic [DW-1:0] item_a(input int k);
        return DW'(k);
    endfunction
    function automatic logic [DW-1:0] item_b(input int k);
        return DW'(k) | 8'h80;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [N-1:0] picks;
        int a_idx, b_idx, s_idx, o_idx;
        logic a_off, b_off, s_off;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 out_vld", out_vld, 0);
        check("R9 a_kill", a_kill, 0);
        check("R9 b_kill", b_kill, 0);

        // R1 / R2: early firing on A, B absent
        @(negedge clk); drive(1, 8'h11, 0, 0, 1, 0); #1;
        check("R1 sel accepted", sel_stop, 0);
        check("R1 a accepted", a_stop, 0);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0); #1;
        check("R1 out_vld", out_vld, 1);
        check("R1 out_data", out_data, 8'h11);
        check("R2 b_kill raised", b_kill, 1);

        // second early firing fills B debt to KILL_DEPTH
        @(negedge clk); drive(1, 8'h22, 0, 0, 1, 0); #1;
        check("R1 second fire", sel_stop, 0);
        @(negedge clk); drive(1, 8'h23, 0, 0, 1, 0); #1;
        check("R5 blocked sel", sel_stop, 1);
        check("R5 a not taken", a_stop, 1);

        // R3: two late B tokens cancel the debt
        @(negedge clk); drive(0, 0, 1, 8'h99, 0, 0); #1;
        check("R3 late b taken", b_stop, 0);
        @(negedge clk); drive(0, 0, 1, 8'h98, 0, 0); #1;
        check("R3 late b taken 2", b_stop, 0);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0); #1;
        check("R3 debt cleared", b_kill, 0);
        check("R3 nothing forwarded", out_vld, 0);

        // R4: full firing, choice B
        @(negedge clk); drive(1, 8'h33, 1, 8'h44, 1, 1); #1;
        check("R4 a taken", a_stop, 0);
        check("R4 b taken", b_stop, 0);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0); #1;
        check("R4 out_data", out_data, 8'h44);
        check("R4 no a debt", a_kill, 0);
        check("R4 no b debt", b_kill, 0);

        // R10: A debt absorbed by producer
        @(negedge clk); drive(0, 0, 1, 8'h55, 1, 1); #1;
        check("R1 b early fire", sel_stop, 0);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0); #1;
        check("R2 a_kill raised", a_kill, 1);
        a_kill_hold = 1'b0;
        @(negedge clk); a_kill_hold = 1'b1; #1;
        check("R10 absorbed", a_kill, 0);

        // R8: stalled output
        out_stop = 1'b1;
        @(negedge clk); drive(1, 8'h61, 1, 8'h71, 1, 0);
        @(negedge clk); drive(1, 8'h62, 1, 8'h72, 1, 0);
        @(negedge clk); drive(1, 8'h63, 1, 8'h73, 1, 0); #1;
        check("R8 full queue blocks", sel_stop, 1);
        check("R8 head data", out_data, 8'h61);
        @(negedge clk); drive(0, 0, 0, 0, 0, 0); #1;
        check("R8 head held", out_data, 8'h61);
        out_stop = 1'b0;
        @(negedge clk); #1;
        check("R8 second item", out_data, 8'h62);
        @(negedge clk); #1;
        check("R8 drained", out_vld, 0);

        // R7: random streams against reference selection
        for (int k = 0; k < N; k++) picks[k] = 1'($urandom);
        a_idx = 0; b_idx = 0; s_idx = 0; o_idx = 0;
        a_off = 0; b_off = 0; s_off = 0;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            if (!a_off && a_idx < N && ($urandom % 3) != 0) a_off = 1;
            if (!b_off && b_idx < N && ($urandom % 3) != 0) b_off = 1;
            if (!s_off && s_idx < N && ($urandom % 2) == 0) s_off = 1;
            a_vld = a_off; a_data = item_a(a_idx);
            a_kill_hold = a_off ? 1'b0 : (($urandom % 4) != 0);
            b_vld = b_off; b_data = item_b(b_idx);
            b_kill_hold = b_off ? 1'b0 : (($urandom % 4) != 0);
            sel_vld = s_off; sel_pick = s_off ? picks[s_idx] : 1'b0;
            out_stop = (($urandom % 3) == 0);
            #1;
            if (a_off && !a_stop) begin a_idx++; a_off = 0; end
            else if (!a_off && a_kill && !a_kill_hold) a_idx++;
            if (b_off && !b_stop) begin b_idx++; b_off = 0; end
            else if (!b_off && b_kill && !b_kill_hold) b_idx++;
            if (s_off && !sel_stop) begin s_idx++; s_off = 0; end
            if (out_vld && !out_stop) begin
                check("R7 stream order", out_data,
                      picks[o_idx] ? item_b(o_idx) : item_a(o_idx));
                o_idx++;
            end
            if (o_idx == N && a_idx == N && b_idx == N) break;
        end
        @(negedge clk); drive(0, 0, 0, 0, 0, 0); #1;
        check("R7 all results", o_idx, N);
        check("R3 a debt balanced", a_kill, 0);
        check("R3 b debt balanced", b_kill, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule